// File: doc/BRIEF.md
# Two-Level Lookup Weight Dequantizer

This block turns 4-bit weights that arrive bit-serially, one bitplane at a time, into signed fixed-point values. The weights are never decoded with shifts, masks or arithmetic. A first, fixed lookup expands each bitplane nibble into a 16-bit fragment in which every bit already sits at its final position. The four fragments of a group are ORed into four bit-parallel codes. A second lookup, a 16-entry table that belongs to the current quantization block, maps each code to its value. Each entry already holds the value with the block's zero point removed and its scale applied.

Software fills a shadow copy of the second table through a write port, one entry per cycle. A block-start strobe then makes the shadow copy the active one. Beats already accepted keep the table they were accepted with. Each accepted input beat gives one output beat of four values, passed straight to the consumer over a valid/ready stream. The input stream can accept one beat per cycle.

Top module: `dq_plane_dequant`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1. Both table banks reset to all-zero entries.
- R2: Nibble p of `in_planes` (bits 4p+3..4p) is bitplane p, with plane 0 the least significant bit of the codes. Bit i of that nibble is bit p of the code of weight i.
- R3: The value of weight i appears on `out_vals[16i+15:16i]`. It equals the active table entry addressed by that weight's code.
- R4: With no backpressure, a beat presented and accepted in cycle c appears with `out_valid` high in cycle c+2, and not earlier.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_vals` holds its value.
- R6: Beats leave in the order they were accepted, with none dropped or duplicated. At most two beats are in flight. `in_ready` is low only when two beats are held and `out_ready` is low.
- R7: A write with `tbl_we` high stores `tbl_data` at `tbl_addr` in the shadow bank only. It changes no output until the next `blk_start`.
- R8: A beat accepted in the same cycle as `blk_start` uses the old active table. A beat accepted in any later cycle uses the new one. After the swap, the shadow bank holds the entries of the previously active bank.
- R9: Table entries are 16-bit signed Q8.8 values and reach the output bit for bit, including the sign bit and extreme values such as 0x8000 and 0x7FFF.
- R10: A table write issued in the same cycle as `blk_start` lands in the bank that becomes active, so it is visible to beats accepted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Shadow-table write enable |
| tbl_addr | input | 4 | Shadow-table entry index (code value) |
| tbl_data | input | 16 | Signed Q8.8 entry value |
| blk_start | input | 1 | Block-start strobe: swap shadow and active tables |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_planes | input | 16 | Four bitplane nibbles, plane 0 in the low nibble |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer ready |
| out_vals | output | 64 | Four signed Q8.8 values, weight 0 in the low 16 bits |

## Verification
The assertions check the stream properties on every cycle: outputs are clear after reset, the output holds under backpressure, an idle pipeline shows the two-cycle latency, at most two beats are in flight, and the input is never blocked while a slot is free. The value mapping can only be shown by the bench's reference model, which compares every output beat: the bitplane-to-code order, the table lookup, the sign handling, and which table a beat sees around a block-start strobe, including writes in the strobe cycle and writes to the shadow bank while beats are in flight.

// File: rtl/dq_pkg.sv
// Shared sizes and types for the two-level lookup dequantizer.
// Assumes one bitplane nibble carries one bit of each of LANES weights.
package dq_pkg;
    parameter int CODE_W  = 4;              // bits per weight code
    parameter int LANES   = 4;              // weights per group
    parameter int VAL_W   = 16;             // Q8.8 value width
    parameter int ENTRIES = 1 << CODE_W;    // stage-two table depth

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [VAL_W-1:0]  val_t;
endpackage

// File: rtl/dq_repack.sv
// Stage one: fixed bit-repacking lookup.
// Each plane nibble indexes a computed table whose entry places bit i of the
// nibble at bit (CODE_W*i + plane) of the group word. The per-plane fragments
// are ORed into LANES bit-parallel codes. Purely combinational.
module dq_repack #(
    parameter int CODE_W = dq_pkg::CODE_W,
    parameter int LANES  = dq_pkg::LANES
) (
    input  logic [CODE_W*LANES-1:0] planes,
    output logic [CODE_W*LANES-1:0] codes
);
    localparam int WORD_W = CODE_W * LANES;

    // Computed table entry for a given plane number and plane index.
    function automatic logic [WORD_W-1:0] frag_of(input int plane, input logic [LANES-1:0] idx);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < LANES; i++) begin
            w[CODE_W*i + plane] = idx[i];
        end
        return w;
    endfunction

    logic [WORD_W-1:0] frag [CODE_W];

    genvar p;
    generate
        for (p = 0; p < CODE_W; p++) begin : g_plane
            // Look up the fragment of plane p.
            assign frag[p] = frag_of(p, planes[LANES*p +: LANES]);
        end
    endgenerate

    // OR all fragments into the bit-parallel code word.
    always_comb begin
        codes = '0;
        for (int k = 0; k < CODE_W; k++) begin
            codes = codes | frag[k];
        end
    end
endmodule

// File: rtl/dq_table.sv
// Stage two: per-block value table, double-buffered.
// Two banks. One is active for lookups, the other is the shadow for writes.
// A swap strobe exchanges their roles at the clock edge, so a lookup made
// in the strobe cycle still reads the old active bank. A write in the strobe
// cycle lands in the bank that becomes active.
module dq_table #(
    parameter int CODE_W = dq_pkg::CODE_W,
    parameter int LANES  = dq_pkg::LANES,
    parameter int VAL_W  = dq_pkg::VAL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CODE_W-1:0]       wr_addr,
    input  logic [VAL_W-1:0]        wr_data,
    input  logic                    swap,
    input  logic [CODE_W*LANES-1:0] rd_codes,
    output logic [VAL_W*LANES-1:0]  rd_vals
);
    localparam int ENTRIES = 1 << CODE_W;

    logic [VAL_W-1:0] bank0 [ENTRIES];
    logic [VAL_W-1:0] bank1 [ENTRIES];
    logic             act_sel;

    // Toggle which bank is active on each block-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) act_sel <= 1'b0;
        else if (swap) act_sel <= ~act_sel;
    end

    // Write the shadow bank; clear both banks in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                bank0[e] <= '0;
                bank1[e] <= '0;
            end
        end else if (wr_en) begin
            if (act_sel) bank0[wr_addr] <= wr_data;
            else         bank1[wr_addr] <= wr_data;
        end
    end

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // Read lane l's value from the active bank.
            assign rd_vals[VAL_W*l +: VAL_W] = act_sel ? bank1[rd_codes[CODE_W*l +: CODE_W]]
                                                       : bank0[rd_codes[CODE_W*l +: CODE_W]];
        end
    endgenerate
endmodule

// File: rtl/dq_stage.sv
// One valid/ready register slice with no bubble: it loads whenever it is
// empty or its content leaves in the same cycle. It holds its data while
// stalled.
module dq_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);
    assign up_ready = !dn_valid || dn_ready;

    // Advance or hold the slice contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
            if (up_valid) dn_data <= up_data;
        end
    end
endmodule

// File: rtl/dq_plane_dequant.sv
// Top: two-level lookup weight dequantizer.
// in_planes -> repack lookup -> value lookup -> slice A -> slice B -> out.
// Both lookups are done in the accept cycle, so each beat is tied to the
// table active when it was accepted. Latency is two cycles, one beat per
// cycle.
module dq_plane_dequant #(
    parameter int CODE_W = dq_pkg::CODE_W,
    parameter int LANES  = dq_pkg::LANES,
    parameter int VAL_W  = dq_pkg::VAL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tbl_we,
    input  logic [CODE_W-1:0]       tbl_addr,
    input  logic [VAL_W-1:0]        tbl_data,
    input  logic                    blk_start,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [CODE_W*LANES-1:0] in_planes,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [VAL_W*LANES-1:0]  out_vals
);
    localparam int OUT_W = VAL_W * LANES;

    logic [CODE_W*LANES-1:0] codes;
    logic [OUT_W-1:0]        looked;
    logic                    mid_valid;
    logic                    mid_ready;
    logic [OUT_W-1:0]        mid_vals;

    dq_repack #(.CODE_W(CODE_W), .LANES(LANES)) u_repack (
        .planes (in_planes),
        .codes  (codes)
    );

    dq_table #(.CODE_W(CODE_W), .LANES(LANES), .VAL_W(VAL_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_data),
        .swap     (blk_start),
        .rd_codes (codes),
        .rd_vals  (looked)
    );

    dq_stage #(.W(OUT_W)) u_slice_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (looked),
        .dn_valid (mid_valid),
        .dn_ready (mid_ready),
        .dn_data  (mid_vals)
    );

    dq_stage #(.W(OUT_W)) u_slice_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (mid_valid),
        .up_ready (mid_ready),
        .up_data  (mid_vals),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (out_vals)
    );
endmodule

// File: rtl/dq_check.sv
// Stream-property checker for dq_plane_dequant, attached by bind.
// It watches only the top module's ports and keeps its own count of beats
// in flight.
module dq_check #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_vals
);
    logic [3:0] inflight;
    logic       was_rst;
    logic       in_fire;
    logic       out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // Remember that the previous cycle was in reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Count accepted beats not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else inflight <= inflight + {3'd0, in_fire} - {3'd0, out_fire};
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (!out_valid && in_ready));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vals)));

    assert_not_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && inflight == 4'd0) |=> !out_valid);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && inflight == 4'd0) |-> ##2 out_valid);

    assert_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 4'd2);

    assert_no_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight < 4'd2) |-> in_ready);
endmodule

bind dq_plane_dequant dq_check #(.DW(VAL_W*LANES)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vals  (out_vals)
);

// File: tb/dq_plane_dequant_test.sv
`timescale 1ns/1ps
module dq_plane_dequant_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        blk_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_planes = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_vals;

    always #2.5 clk = ~clk;

    dq_plane_dequant uut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .blk_start(blk_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_planes(in_planes), .out_valid(out_valid),
        .out_ready(out_ready), .out_vals(out_vals)
    );

    typedef struct {
        logic [63:0] vals;
        int          acc;
        int          vis;
    } beat_t;

    logic [15:0] act_t [16];
    logic [15:0] shd_t [16];
    beat_t       pend [$];
    int          cyc = 0;
    int          errors = 0;
    int          checks = 0;
    int          wd = 0;
    string       tag = "R3";
    bit          fired_last = 1'b0;

    task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", t, cyc, act, exp);
        end
    endtask

    // Expected beat: rebuild each code from its planes, then read the active table.
    function automatic logic [63:0] model_beat(input logic [15:0] pl);
        logic [63:0] r;
        for (int i = 0; i < 4; i++) begin
            logic [3:0] c;
            for (int p = 0; p < 4; p++) c[p] = pl[4*p + i];
            r[16*i +: 16] = act_t[c];
        end
        return r;
    endfunction

    // Reference model: compare outputs, then apply the handshakes of the coming edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_ready, exp_valid, ofire, ifire;
            exp_ready = !(pend.size() == 2 && !out_ready);
            exp_valid = pend.size() > 0 && pend[0].vis <= cyc - 1;
            chk(in_ready == exp_ready, "R6", {63'd0, in_ready}, {63'd0, exp_ready});
            chk(out_valid == exp_valid, "R4", {63'd0, out_valid}, {63'd0, exp_valid});
            if (exp_valid) chk(out_vals == pend[0].vals, tag, out_vals, pend[0].vals);
            ofire = exp_valid && out_ready;
            ifire = in_valid && exp_ready;
            if (ofire) begin
                void'(pend.pop_front());
                if (pend.size() > 0)
                    pend[0].vis = (pend[0].acc + 1 > cyc) ? pend[0].acc + 1 : cyc;
            end
            if (ifire) begin
                beat_t b;
                b.vals = model_beat(in_planes);
                b.acc  = cyc;
                b.vis  = (pend.size() == 0) ? cyc + 1 : 0;
                pend.push_back(b);
            end
            fired_last = ifire;
            if (tbl_we) shd_t[tbl_addr] = tbl_data;
            if (blk_start) begin
                for (int e = 0; e < 16; e++) begin
                    logic [15:0] tmp;
                    tmp = act_t[e];
                    act_t[e] = shd_t[e];
                    shd_t[e] = tmp;
                end
            end
        end
        cyc++;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", wd, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Random traffic with optional shadow writes and a strobe at cycle strobe_at.
    task automatic run(input int n, input int vpct, input int rpct, input int wpct, input int strobe_at);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            if (!in_valid || fired_last) begin
                in_valid  = ($urandom % 100) < vpct;
                in_planes = 16'($urandom);
            end
            out_ready = ($urandom % 100) < rpct;
            tbl_we    = ($urandom % 100) < wpct;
            tbl_addr  = 4'($urandom);
            tbl_data  = 16'($urandom);
            blk_start = (k == strobe_at);
        end
        @(posedge clk); #1;
        tbl_we = 1'b0;
        blk_start = 1'b0;
    endtask

    // Drain the pipeline with the input idle.
    task automatic drain();
        @(posedge clk); #1;
        if (in_valid && !fired_last) begin
            out_ready = 1'b1;
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        tbl_we = 1'b0;
        blk_start = 1'b0;
        repeat (5) @(posedge clk);
        #1;
    endtask

    // Load all 16 shadow entries; the last write shares its cycle with the strobe (R10).
    task automatic load_affine(input int zp, input int scale);
        for (int q = 0; q < 16; q++) begin
            @(posedge clk); #1;
            tbl_we    = 1'b1;
            tbl_addr  = 4'(q);
            tbl_data  = 16'((q - zp) * scale);
            blk_start = (q == 15);
        end
        @(posedge clk); #1;
        tbl_we = 1'b0;
        blk_start = 1'b0;
    endtask

    task automatic load_extremes();
        for (int q = 0; q < 16; q++) begin
            @(posedge clk); #1;
            tbl_we    = 1'b1;
            tbl_addr  = 4'(q);
            tbl_data  = (q % 2 == 0) ? (16'h8000 | 16'(q)) : (16'h7FF0 | 16'(q));
            blk_start = (q == 15);
        end
        @(posedge clk); #1;
        tbl_we = 1'b0;
        blk_start = 1'b0;
    endtask

    initial begin
        for (int e = 0; e < 16; e++) begin
            act_t[e] = '0;
            shd_t[e] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: state in the first cycle after reset.
        chk(out_valid == 1'b0, "R1", {63'd0, out_valid}, 64'd0);
        chk(in_ready == 1'b1, "R1", {63'd0, in_ready}, 64'd1);
        tag = "R1";
        run(8, 100, 100, 0, -1);    // zeroed tables give zero values
        drain();

        tag = "R10";
        load_affine(8, 16'h0100);
        tag = "R3";
        run(40, 100, 100, 0, -1);
        drain();

        tag = "R10";
        load_affine(5, 16'h0120);
        tag = "R2";
        run(60, 100, 100, 0, -1);
        drain();

        tag = "R9";
        load_extremes();
        run(40, 100, 100, 0, -1);
        drain();

        tag = "R5";
        run(300, 70, 35, 0, -1);
        drain();

        tag = "R7";
        run(300, 80, 70, 60, -1);
        drain();

        tag = "R8";
        run(200, 90, 60, 50, 40);
        run(200, 90, 80, 50, 100);
        drain();

        tag = "R4";
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            in_valid  = 1'b1;
            in_planes = 16'($urandom);
            @(posedge clk); #1;
            in_valid = 1'b0;
            repeat (3) @(posedge clk);
            #1;
        end
        drain();
        chk(pend.size() == 0, "R6", 64'(pend.size()), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule